// File: doc/BRIEF.md
# Serial Character Receiver with Four-Entry Status Queue

This block turns an asynchronous serial line into characters. A clock-enable pulse at sixteen times the bit rate paces it. It waits for a falling edge and confirms the start bit half a bit later. It then samples each following bit at its centre and checks the stop bit or bits. The finished character goes into a small first-in first-out queue together with its own parity and framing status. Software, or a neighbouring controller, pops characters from the head of the queue through a read strobe. A two-bit format input selects one of four frame shapes: 8 bits with no parity, 8 bits with even parity, 8 bits with odd parity, or 9 bits with no parity. A further input selects one or two stop bits.

Status outputs show whether data is waiting, whether the receiver is between characters, and whether a character was lost to a full queue. An overrun freezes the receiver until a clear pulse, which also empties the queue. An interrupt pulse can follow every stored character, or only the one that brings the queue to three entries, or only the one that fills it. In the 9-bit multidrop mode, a filter keeps only characters whose ninth bit is set, so that a node hears address characters and ignores traffic for other nodes.

Top module: `uart_rx_fifo`

## Requirements
- R1: Bits arrive least significant first. With `frame_fmt` 00 (8 data bits, no parity), 01 (8 bits plus even parity) or 10 (8 bits plus odd parity), `rd_data` shows the 8 data bits in bits 7:0, and bit 8 is 0. With 11 (9 data bits, no parity), `rd_data` shows all 9 bits.
- R2: `rd_perr` is 1 for a stored character when the received parity bit disagrees with the selected even or odd parity. It is always 0 in the two formats that have no parity.
- R3: `rd_ferr` is 1 when the first stop bit samples low. In two-stop mode (`two_stop`=1) a low second stop bit does not set it.
- R4: Characters are read in arrival order from a 4-entry queue. `data_avail` is 1 exactly when the queue is not empty. A one-cycle `rd_en` pulse removes the head entry. The head entry and its flags stay unchanged while nothing is read.
- R5: `rx_idle` is 0 while a character is being shifted in and 1 otherwise, including after reset.
- R6: A low pulse shorter than half a bit is not taken as a start bit. It stores nothing and the receiver returns to idle.
- R7: `irq` pulses for one cycle when a character is stored, filtered by `irq_sel`. Values 00 and 01 give a pulse for every character. 10 gives a pulse only when the store brings the queue to 3 entries. 11 gives a pulse only when the store brings it to 4 entries.
- R8: When a character completes while the queue holds 4 entries, `overrun` goes to 1 and the character is dropped. The queue keeps its contents, and the receiver ignores the line until an `ovr_clr` pulse. That pulse clears `overrun` and empties the queue.
- R9: With `addr_only`=1 and `frame_fmt`=11, a character whose bit 8 is 0 is dropped and one whose bit 8 is 1 is stored. In the other formats `addr_only` has no effect.
- R10: An `rd_en` pulse while the queue is empty has no effect. `rd_data` and its flags read as 0 while the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_in | input | 1 | Serial line, idles high |
| baud_tick | input | 1 | One-cycle enable at 16x the bit rate |
| frame_fmt | input | 2 | Frame shape select (see R1) |
| two_stop | input | 1 | 1 selects two stop bits |
| irq_sel | input | 2 | Interrupt fill-level select (see R7) |
| addr_only | input | 1 | Keep only 9-bit characters with bit 8 set |
| rd_en | input | 1 | Pop the head entry |
| ovr_clr | input | 1 | Clear the overrun and empty the queue |
| rd_data | output | 9 | Head character |
| rd_perr | output | 1 | Parity error of the head character |
| rd_ferr | output | 1 | Framing error of the head character |
| data_avail | output | 1 | Queue not empty |
| rx_idle | output | 1 | No character being shifted in |
| overrun | output | 1 | Character lost to a full queue; receiver halted |
| irq | output | 1 | Fill-level interrupt pulse |

## Verification
Each of the four frame formats is swept with both stop-bit settings and a spread of data values that includes all-zeros and all-ones. On chosen frames the bench flips the parity bit or pulls a stop bit low. This separates a bit-order or width fault from a parity-sense fault, and it shows whether a bad first stop bit is told apart from a bad second one. Bursts of four characters under each interrupt setting show whether the threshold compare uses the right fill count and whether the queue keeps order. Two further sequences cover the filtering rules and the halt-then-flush rule: a fifth and sixth character arriving at a full queue, and unaddressed 9-bit traffic mixed with addressed characters.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int CHAR_W = 9;

    localparam logic [1:0] FMT_8N = 2'b00;
    localparam logic [1:0] FMT_8E = 2'b01;
    localparam logic [1:0] FMT_8O = 2'b10;
    localparam logic [1:0] FMT_9N = 2'b11;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_START,
        PH_BITS,
        PH_STOP
    } rx_phase_e;

    typedef struct packed {
        logic [CHAR_W-1:0] data;
        logic              perr;
        logic              ferr;
    } rx_entry_t;

    // Turn the shift register contents into a stored entry for the selected format.
    function automatic rx_entry_t build_entry(input logic [1:0] fmt,
                                              input logic [CHAR_W-1:0] sh,
                                              input logic ferr);
        rx_entry_t e;
        e.ferr = ferr;
        e.perr = 1'b0;
        unique case (fmt)
            FMT_8N: e.data = {1'b0, sh[CHAR_W-1:1]};
            FMT_8E: begin
                e.data = {1'b0, sh[CHAR_W-2:0]};
                e.perr = ^sh;
            end
            FMT_8O: begin
                e.data = {1'b0, sh[CHAR_W-2:0]};
                e.perr = ~^sh;
            end
            default: e.data = sh;
        endcase
        return e;
    endfunction

endpackage

// File: rtl/uart_rx_sampler.sv
module uart_rx_sampler
    import uart_rx_pkg::*;
#(
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_in,
    input  logic       tick,
    input  logic       run,
    input  logic [1:0] fmt,
    input  logic       two_stop,
    output rx_entry_t  word_o,
    output logic       done_o,
    output logic       busy_o
);
    localparam int CW = $clog2(OVS);
    localparam logic [CW-1:0] LAST = CW'(OVS - 1);
    localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        rx_phase_e              phase;
        logic [CW-1:0]          cnt;
        logic [3:0]             nbit;
        logic [CHAR_W-1:0]      sh;
        logic                   second;
        logic                   ferr;
        logic                   done;
        rx_entry_t              word;
    } smp_state_t;

    localparam smp_state_t SMP_RESET = '{
        sync:   '1,
        phase:  PH_IDLE,
        cnt:    '0,
        nbit:   '0,
        sh:     '0,
        second: 1'b0,
        ferr:   1'b0,
        done:   1'b0,
        word:   '0
    };

    smp_state_t s_q, s_d;
    logic       rx_s;
    logic [3:0] last_bit;
    logic       ferr_now;

    assign rx_s     = s_q.sync[SYNC_STAGES-1];
    assign last_bit = (fmt == FMT_8N) ? 4'd7 : 4'd8;
    assign ferr_now = s_q.second ? s_q.ferr : ~rx_s;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        s_d.sync = {s_q.sync[SYNC_STAGES-2:0], rx_in};
        unique case (s_q.phase)
            PH_IDLE: begin
                if (tick && run && !rx_s) begin
                    s_d.phase = PH_START;
                    s_d.cnt   = '0;
                end
            end
            PH_START: begin
                if (tick) begin
                    if (s_q.cnt == MID) begin
                        s_d.cnt    = '0;
                        s_d.nbit   = '0;
                        s_d.second = 1'b0;
                        s_d.ferr   = 1'b0;
                        s_d.phase  = rx_s ? PH_IDLE : PH_BITS;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
            end
            PH_BITS: begin
                if (tick) begin
                    if (s_q.cnt == LAST) begin
                        s_d.cnt  = '0;
                        s_d.sh   = {rx_s, s_q.sh[CHAR_W-1:1]};
                        s_d.nbit = s_q.nbit + 1'b1;
                        if (s_q.nbit == last_bit) begin
                            s_d.phase = PH_STOP;
                        end
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
            end
            default: begin
                if (tick) begin
                    if (s_q.cnt == LAST) begin
                        s_d.cnt = '0;
                        if (!s_q.second && two_stop) begin
                            s_d.second = 1'b1;
                            s_d.ferr   = ~rx_s;
                        end else begin
                            s_d.phase = PH_IDLE;
                            s_d.done  = 1'b1;
                            s_d.word  = build_entry(fmt, s_q.sh, ferr_now);
                        end
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= SMP_RESET;
        else        s_q <= s_d;
    end

    assign word_o = s_q.word;
    assign done_o = s_q.done;
    assign busy_o = (s_q.phase != PH_IDLE);

endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        push,
    input  rx_entry_t                   push_entry,
    input  logic                        pop,
    input  logic                        flush,
    output rx_entry_t                   head,
    output logic                        empty,
    output logic                        full,
    output logic [$clog2(DEPTH+1)-1:0]  fill_nxt
);
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNTW = $clog2(DEPTH + 1);
    localparam logic [CNTW-1:0] FULL_CNT = CNTW'(DEPTH);
    localparam logic [PW-1:0]   LAST_PTR = PW'(DEPTH - 1);

    typedef struct packed {
        rx_entry_t [DEPTH-1:0] slot;
        logic [PW-1:0]         wr;
        logic [PW-1:0]         rd;
        logic [CNTW-1:0]       fill;
    } q_state_t;

    q_state_t q_q, q_d;
    logic     do_push, do_pop;

    assign empty   = (q_q.fill == '0);
    assign full    = (q_q.fill == FULL_CNT);
    assign do_pop  = pop && !empty && !flush;
    assign do_push = push && !full && !flush;

    always_comb begin
        q_d = q_q;
        if (flush) begin
            q_d.wr   = '0;
            q_d.rd   = '0;
            q_d.fill = '0;
        end else begin
            if (do_push) begin
                q_d.slot[q_q.wr] = push_entry;
                q_d.wr = (q_q.wr == LAST_PTR) ? '0 : q_q.wr + 1'b1;
            end
            if (do_pop) begin
                q_d.rd = (q_q.rd == LAST_PTR) ? '0 : q_q.rd + 1'b1;
            end
            q_d.fill = q_q.fill + CNTW'(do_push) - CNTW'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign head     = empty ? '0 : q_q.slot[q_q.rd];
    assign fill_nxt = q_d.fill;

endmodule

// File: rtl/uart_rx_irq.sv
module uart_rx_irq #(
    parameter int DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [1:0]                 sel,
    input  logic                       stored,
    input  logic [$clog2(DEPTH+1)-1:0] fill_nxt,
    output logic                       irq
);
    localparam int CNTW = $clog2(DEPTH + 1);
    localparam logic [CNTW-1:0] NEAR_CNT = CNTW'(DEPTH - 1);
    localparam logic [CNTW-1:0] FULL_CNT = CNTW'(DEPTH);

    typedef struct packed {
        logic irq;
    } irq_state_t;

    irq_state_t i_q, i_d;
    logic       level_hit;

    always_comb begin
        unique case (sel)
            2'b10:   level_hit = (fill_nxt == NEAR_CNT);
            2'b11:   level_hit = (fill_nxt == FULL_CNT);
            default: level_hit = 1'b1;
        endcase
        i_d.irq = stored && level_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) i_q <= '0;
        else        i_q <= i_d;
    end

    assign irq = i_q.irq;

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
    import uart_rx_pkg::*;
#(
    parameter int OVS         = 16,
    parameter int DEPTH       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_in,
    input  logic              baud_tick,
    input  logic [1:0]        frame_fmt,
    input  logic              two_stop,
    input  logic [1:0]        irq_sel,
    input  logic              addr_only,
    input  logic              rd_en,
    input  logic              ovr_clr,
    output logic [CHAR_W-1:0] rd_data,
    output logic              rd_perr,
    output logic              rd_ferr,
    output logic              data_avail,
    output logic              rx_idle,
    output logic              overrun,
    output logic              irq
);
    localparam int CNTW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic overrun;
    } top_state_t;

    top_state_t t_q, t_d;
    rx_entry_t  word, head;
    logic       done, busy, q_empty, q_full;
    logic       accept, store;
    logic [CNTW-1:0] fill_nxt;

    uart_rx_sampler #(.OVS(OVS), .SYNC_STAGES(SYNC_STAGES)) u_sampler (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_in    (rx_in),
        .tick     (baud_tick),
        .run      (!t_q.overrun),
        .fmt      (frame_fmt),
        .two_stop (two_stop),
        .word_o   (word),
        .done_o   (done),
        .busy_o   (busy)
    );

    always_comb begin
        accept  = done && !(addr_only && (frame_fmt == FMT_9N) && !word.data[CHAR_W-1]);
        store   = accept && !q_full && !ovr_clr;
        t_d     = t_q;
        if (ovr_clr)              t_d.overrun = 1'b0;
        else if (accept && q_full) t_d.overrun = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    uart_rx_queue #(.DEPTH(DEPTH)) u_queue (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (store),
        .push_entry (word),
        .pop        (rd_en),
        .flush      (ovr_clr),
        .head       (head),
        .empty      (q_empty),
        .full       (q_full),
        .fill_nxt   (fill_nxt)
    );

    uart_rx_irq #(.DEPTH(DEPTH)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (irq_sel),
        .stored   (store),
        .fill_nxt (fill_nxt),
        .irq      (irq)
    );

    assign rd_data    = head.data;
    assign rd_perr    = head.perr;
    assign rd_ferr    = head.ferr;
    assign data_avail = !q_empty;
    assign rx_idle    = !busy;
    assign overrun    = t_q.overrun;

endmodule

// File: rtl/uart_rx_fifo_checker.sv
module uart_rx_fifo_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_en,
    input logic       ovr_clr,
    input logic [8:0] rd_data,
    input logic       data_avail,
    input logic       rx_idle,
    input logic       overrun,
    input logic       irq
);
    assert_avail_falls_on_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(data_avail) |-> ($past(rd_en) || $past(ovr_clr)));

    assert_head_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (data_avail && !rd_en && !ovr_clr) |=> $stable(rd_data));

    assert_halted_is_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> rx_idle);

    assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !ovr_clr) |=> overrun);

    assert_clear_flushes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_clr |=> (!data_avail && !overrun));

    assert_overrun_needs_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> data_avail);

    assert_irq_has_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> data_avail);

    assert_empty_reads_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !data_avail |-> (rd_data == 9'd0));

endmodule

bind uart_rx_fifo uart_rx_fifo_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en      (rd_en),
    .ovr_clr    (ovr_clr),
    .rd_data    (rd_data),
    .data_avail (data_avail),
    .rx_idle    (rx_idle),
    .overrun    (overrun),
    .irq        (irq)
);

// File: tb/uart_rx_fifo_bench.sv
module uart_rx_fifo_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_in = 1'b1;
    logic       baud_tick = 1'b0;
    logic [1:0] frame_fmt = 2'b00;
    logic       two_stop = 1'b0;
    logic [1:0] irq_sel = 2'b00;
    logic       addr_only = 1'b0;
    logic       rd_en = 1'b0;
    logic       ovr_clr = 1'b0;
    logic [8:0] rd_data;
    logic       rd_perr, rd_ferr, data_avail, rx_idle, overrun, irq;

    int vectors = 0;
    int fails = 0;
    int irq_cnt = 0;
    bit done_flag = 0;
    logic tick_div = 1'b0;

    localparam int BIT_CLKS = 32;

    always #2 clk = ~clk;

    always @(posedge clk) begin
        tick_div  <= ~tick_div;
        baud_tick <= tick_div;
        if (rst_n && irq) irq_cnt <= irq_cnt + 1;
    end

    uart_rx_fifo u_uart_rx_fifo (
        .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .baud_tick(baud_tick),
        .frame_fmt(frame_fmt), .two_stop(two_stop), .irq_sel(irq_sel),
        .addr_only(addr_only), .rd_en(rd_en), .ovr_clr(ovr_clr),
        .rd_data(rd_data), .rd_perr(rd_perr), .rd_ferr(rd_ferr),
        .data_avail(data_avail), .rx_idle(rx_idle), .overrun(overrun), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    // idle_exp: -1 no probe, else expected rx_idle at mid of data bit 3
    task automatic send_frame(input logic [8:0] d, input logic [1:0] fmt, input bit two,
                              input bit bad_par, input bit bad1, input bit bad2,
                              input int idle_exp);
        int nb;
        logic p;
        nb = (fmt == 2'b11) ? 9 : 8;
        rx_in = 1'b0;
        wait_clks(BIT_CLKS);
        for (int i = 0; i < nb; i++) begin
            rx_in = d[i];
            wait_clks(BIT_CLKS / 2);
            if (i == 3 && idle_exp >= 0)
                chk(rx_idle == idle_exp[0], "R5 rx_idle mid-frame", rx_idle, idle_exp);
            wait_clks(BIT_CLKS / 2);
        end
        if (fmt == 2'b01 || fmt == 2'b10) begin
            p = (fmt == 2'b01) ? ^d[7:0] : ~^d[7:0];
            rx_in = p ^ bad_par;
            wait_clks(BIT_CLKS);
        end
        rx_in = ~bad1;
        wait_clks(24);
        rx_in = 1'b1;
        wait_clks(BIT_CLKS - 24);
        if (two) begin
            rx_in = ~bad2;
            wait_clks(24);
            rx_in = 1'b1;
            wait_clks(BIT_CLKS - 24);
        end
        wait_clks(BIT_CLKS);
    endtask

    task automatic pop;
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic expect_head(input logic [8:0] d, input bit pe, input bit fe, input string req);
        chk(data_avail == 1'b1, req, data_avail, 1);
        chk(rd_data == d, req, rd_data, d);
        chk(rd_perr == pe && rd_ferr == fe, req, {rd_perr, rd_ferr}, {pe, fe});
    endtask

    initial begin
        wait_clks(5);
        chk(data_avail == 1'b0, "R4 reset avail", data_avail, 0);
        chk(rx_idle == 1'b1, "R5 reset idle", rx_idle, 1);
        chk(overrun == 1'b0 && irq == 1'b0, "R8 reset overrun/irq", {overrun, irq}, 0);
        rst_n = 1'b1;
        wait_clks(10);

        // R1 R2 R3 R7: sweep formats, stop settings and data values, one character at a time
        for (int f = 0; f < 4; f++) begin
            for (int two = 0; two < 2; two++) begin
                for (int i = 0; i < 12; i++) begin
                    logic [8:0] v, expd;
                    bit bp, b1, b2, pe;
                    int irq_before;
                    v = (i == 0) ? 9'h000 : (i == 11) ? 9'h1FF : 9'((i * 173 + f * 31 + 5) % 512);
                    bp = (f == 1 || f == 2) && (i % 3 == 1);
                    b1 = (i % 5 == 2);
                    b2 = (two == 1) && (i % 4 == 3) && !b1;
                    pe = bp;
                    expd = (f == 3) ? v : {1'b0, v[7:0]};
                    frame_fmt = 2'(f);
                    two_stop = 1'(two);
                    irq_sel = 2'(i % 2);
                    irq_before = irq_cnt;
                    send_frame(v, 2'(f), 1'(two), bp, b1, b2, (i == 4) ? 0 : -1);
                    expect_head(expd, pe, b1, "R1 R2 R3 sweep entry");
                    chk(irq_cnt == irq_before + 1, "R7 irq per char", irq_cnt - irq_before, 1);
                    chk(rx_idle == 1'b1, "R5 idle after frame", rx_idle, 1);
                    pop();
                    chk(data_avail == 1'b0, "R4 empty after pop", data_avail, 0);
                end
            end
        end

        // R6: short low glitch
        frame_fmt = 2'b00; two_stop = 1'b0; irq_sel = 2'b00;
        rx_in = 1'b0; wait_clks(6); rx_in = 1'b1;
        wait_clks(600);
        chk(data_avail == 1'b0, "R6 glitch stores nothing", data_avail, 0);
        chk(rx_idle == 1'b1, "R6 glitch back to idle", rx_idle, 1);

        // R7 thresholds and R4 ordering
        for (int s = 2; s < 4; s++) begin
            irq_sel = 2'(s);
            for (int k = 0; k < 4; k++) begin
                int irq_before, exp_inc;
                irq_before = irq_cnt;
                send_frame(9'(8'h30 + k), 2'b00, 1'b0, 0, 0, 0, -1);
                exp_inc = ((s == 2 && k == 2) || (s == 3 && k == 3)) ? 1 : 0;
                chk(irq_cnt - irq_before == exp_inc, "R7 threshold irq", irq_cnt - irq_before, exp_inc);
            end
            for (int k = 0; k < 4; k++) begin
                expect_head(9'(8'h30 + k), 0, 0, "R4 queue order");
                pop();
            end
            chk(data_avail == 1'b0, "R4 drained", data_avail, 0);
        end

        // R8 overrun
        irq_sel = 2'b00;
        for (int k = 0; k < 4; k++) send_frame(9'(8'h50 + k), 2'b00, 1'b0, 0, 0, 0, -1);
        chk(overrun == 1'b0, "R8 no overrun at 4", overrun, 0);
        send_frame(9'h0AA, 2'b00, 1'b0, 0, 0, 0, -1);
        chk(overrun == 1'b1, "R8 overrun set", overrun, 1);
        expect_head(9'h050, 0, 0, "R8 head kept");
        send_frame(9'h0BB, 2'b00, 1'b0, 0, 0, 0, 1);
        chk(overrun == 1'b1, "R8 overrun held", overrun, 1);
        ovr_clr = 1'b1; @(negedge clk); ovr_clr = 1'b0; @(negedge clk);
        chk(overrun == 1'b0 && data_avail == 1'b0, "R8 clear flushes", {overrun, data_avail}, 0);
        send_frame(9'h0C3, 2'b00, 1'b0, 0, 0, 0, -1);
        expect_head(9'h0C3, 0, 0, "R8 reception resumes");
        pop();

        // R9 address filter
        addr_only = 1'b1; frame_fmt = 2'b11;
        send_frame(9'h0AA, 2'b11, 1'b0, 0, 0, 0, -1);
        chk(data_avail == 1'b0, "R9 data char dropped", data_avail, 0);
        send_frame(9'h1AB, 2'b11, 1'b0, 0, 0, 0, -1);
        expect_head(9'h1AB, 0, 0, "R9 address char kept");
        pop();
        frame_fmt = 2'b00;
        send_frame(9'h0AA, 2'b00, 1'b0, 0, 0, 0, -1);
        expect_head(9'h0AA, 0, 0, "R9 filter ignored in 8-bit");
        pop();
        addr_only = 1'b0;

        // R10 read on empty
        chk(rd_data == 9'd0, "R10 empty reads zero", rd_data, 0);
        pop();
        chk(data_avail == 1'b0, "R10 empty pop no effect", data_avail, 0);
        send_frame(9'h05A, 2'b00, 1'b0, 0, 0, 0, -1);
        expect_head(9'h05A, 0, 0, "R10 next char intact");
        pop();
        chk(data_avail == 1'b0, "R10 single entry only", data_avail, 0);

        if (!done_flag) begin
            done_flag = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1;
            vectors++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule